// File: doc/BRIEF.md
# BF16 Pairwise Dot-Product Accumulator

This block takes two source vectors and an FP32 accumulator vector. It splits each source vector into 32-bit lanes, and each lane holds two BF16 values. In every active lane it multiplies the two matching BF16 elements of the sources and adds the two products into one single-precision sum. It then adds that sum to the accumulator element of the same lane. The result replaces that element in the output vector.

`wide_mode` selects the lane count. With it set there are four lanes over 128 bits. With it clear there are two lanes over the low 64 bits. In broadcast mode only the low 64 bits of the second source are used. `bcast_sel` picks one of its two 32-bit BF16 pairs, and that pair feeds every lane.

The arithmetic rules are fixed:
- Rounding is round-to-nearest-even.
- Subnormal values are flushed to signed zero, whether they are operands or results.
- Every NaN result is the default quiet NaN.
- No exception flags are kept.

One shared multiply/add datapath processes the lanes one after another. A sequencer with five states drives it:
- `ST_IDLE` waits for `start`. On `start` it takes the transition `accept` to `ST_MUL`.
- `ST_MUL` registers both lane products. It then takes `mul_to_sum` to `ST_PSUM`.
- `ST_PSUM` registers the FP32 sum of the two products. It then takes `sum_to_acc` to `ST_ACCUM`.
- `ST_ACCUM` adds that sum to the lane's accumulator and writes the lane back. It then takes `next_lane` back to `ST_MUL`, or `last_lane` to `ST_FIN`.
- `ST_FIN` raises `done` for one cycle and takes `retire` to `ST_IDLE`.

Top module: `bfdot_acc_unit`

## Requirements
- R1: Lane e occupies bits [32e+31:32e] of each vector. In each source lane, the element in bits [15:0] is paired with the same field of the other source, and so is the element in bits [31:16]. The output lane is (accumulator lane + (a_lo*b_lo + a_hi*b_hi)).
- R2: With `wide_mode`=1, all four lanes are processed. With `wide_mode`=0, only lanes 0 and 1 are processed, and `acc_out[127:64]` equals `acc_in[127:64]` as captured at start.
- R3: With `bcast_mode`=1, the pair `vec_b[31:0]` (`bcast_sel`=0) or `vec_b[63:32]` (`bcast_sel`=1) is used as the second operand of every lane. `vec_b[127:64]` has no effect in this mode.
- R4: The two products are first rounded to an FP32 sum, and that sum is then added to the accumulator with a second rounding. Both roundings are to nearest, with ties to even.
- R5: Any NaN input, infinity times zero, and the sum of opposite-signed infinities all yield the default NaN 0x7FC00000.
- R6: A product or sum beyond the FP32 range gives an infinity of the correct sign. A tiny addend to the largest finite value leaves that value unchanged.
- R7: Subnormal inputs and subnormal results become zero with their sign kept. An exact zero sum of opposite-signed values is +0. The sum of two -0 values is -0.
- R8: `busy` is high from the cycle after `start` is accepted until `done`. `done` is a one-cycle pulse seen 3*lanes+1 cycles after the accepting edge (7 for two lanes, 13 for four). It is followed by `busy` low.
- R9: `start` has no effect while `busy` is high. Operands and mode inputs are captured at the accepting edge, so later changes to them have no effect.
- R10: After reset, `busy`, `done` and `acc_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request an operation; accepted only when idle |
| wide_mode | input | 1 | 1: four lanes (128 bits); 0: two lanes (64 bits) |
| bcast_mode | input | 1 | 1: broadcast one pair of vec_b to all lanes |
| bcast_sel | input | 1 | Pair chosen in broadcast mode (0: bits 31:0, 1: bits 63:32) |
| vec_a | input | 128 | First source, BF16 pairs per lane |
| vec_b | input | 128 | Second source, BF16 pairs per lane |
| acc_in | input | 128 | FP32 accumulator lanes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 128 | Accumulated FP32 lanes; valid from `done` until the next start |

## Verification
A lane counter that slips or a wrong last-lane limit shows up as a changed `done` latency (not 7 or 13 cycles). It also shows up as a wrong value in an untouched upper lane of the two-lane form, and it is visible in the first result read at `done`. A broken adder-operand mux, or a sum register loaded at the wrong state, corrupts the affected lane on the same `done`. The rounding, cancellation and signed-zero vectors make a wrong guard or sticky bit visible as an LSB error. Sequencer faults, such as a stuck `ST_FIN` or a missed return to idle, show one cycle after `done` as `busy` still high or `done` held.

// File: rtl/bfdot_pkg.sv
package bfdot_pkg;

    localparam int unsigned FP_W   = 32;
    localparam int unsigned BF_W   = 16;
    localparam int unsigned EXP_W  = 8;
    localparam int unsigned FRAC_W = 23;
    localparam int unsigned EXT_W  = FRAC_W + 4;          // hidden bit + fraction + guard/round/sticky
    localparam int unsigned LZ_W   = $clog2(EXT_W + 1);

    localparam logic [FP_W-1:0] FP32_QNAN = 32'h7FC0_0000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL,
        ST_PSUM,
        ST_ACCUM,
        ST_FIN
    } seq_state_t;

    // Leading-zero count over the extended significand; returns EXT_W for zero.
    function automatic logic [LZ_W-1:0] lzc_ext(input logic [EXT_W-1:0] v);
        logic [LZ_W-1:0] n;
        n = LZ_W'(EXT_W);
        for (int i = 0; i < EXT_W; i++) begin
            if (v[i]) n = LZ_W'(EXT_W - 1 - i);
        end
        return n;
    endfunction

endpackage

// File: rtl/bf16_mul.sv
// BF16 x BF16 -> FP32. The 8x8-bit significand product always fits in an
// FP32 fraction, so only range limits (overflow / flush) need handling.
module bf16_mul
    import bfdot_pkg::*;
(
    input  logic [BF_W-1:0] a_i,
    input  logic [BF_W-1:0] b_i,
    output logic [FP_W-1:0] p_o
);

    always_comb begin
        logic              sa, sb, sp;
        logic [EXP_W-1:0]  ea, eb;
        logic [6:0]        fa, fb;
        logic              anan, bnan, ainf, binf, azr, bzr;
        logic [15:0]       prod;
        logic signed [9:0] ep;
        logic [FRAC_W-1:0] fp;

        sa = a_i[15];  ea = a_i[14:7];  fa = a_i[6:0];
        sb = b_i[15];  eb = b_i[14:7];  fb = b_i[6:0];
        sp = sa ^ sb;

        anan = (ea == '1) && (fa != '0);
        bnan = (eb == '1) && (fb != '0);
        ainf = (ea == '1) && (fa == '0);
        binf = (eb == '1) && (fb == '0);
        azr  = (ea == '0);                 // zero or flushed subnormal
        bzr  = (eb == '0);

        prod = 16'({1'b1, fa}) * 16'({1'b1, fb});
        ep   = $signed({2'b00, ea}) + $signed({2'b00, eb}) - 10'sd127;
        if (prod[15]) begin
            fp = {prod[14:0], 8'h00};
            ep = ep + 10'sd1;
        end else begin
            fp = {prod[13:0], 9'h000};
        end

        if (anan || bnan)
            p_o = FP32_QNAN;
        else if ((ainf && bzr) || (binf && azr))
            p_o = FP32_QNAN;
        else if (ainf || binf)
            p_o = {sp, 8'hFF, 23'h0};
        else if (azr || bzr)
            p_o = {sp, 31'h0};
        else if (ep >= 10'sd255)
            p_o = {sp, 8'hFF, 23'h0};
        else if (ep <= 10'sd0)
            p_o = {sp, 31'h0};
        else
            p_o = {sp, ep[7:0], fp};
    end

endmodule

// File: rtl/fp32_add.sv
// FP32 adder, round-to-nearest-even, subnormals flushed, default NaN.
module fp32_add
    import bfdot_pkg::*;
(
    input  logic [FP_W-1:0] x_i,
    input  logic [FP_W-1:0] y_i,
    output logic [FP_W-1:0] z_o
);

    always_comb begin
        logic              sx, sy, bs, ss, swap, sub, stk, tiny, g, rs, up;
        logic [EXP_W-1:0]  ex, ey, be, se, dexp;
        logic [FRAC_W-1:0] fx, fy, bf, sf, frac;
        logic              xnan, ynan, xinf, yinf, xzr, yzr;
        logic [EXT_W-1:0]  mb, ms, msh, norm;
        logic [EXT_W:0]    sum_w;
        logic [LZ_W-1:0]   lz;
        logic signed [9:0] ew;
        logic [FRAC_W:0]   mant;
        logic [FRAC_W+1:0] mrnd;
        logic [FP_W-1:0]   gen;

        sx = x_i[31];  ex = x_i[30:23];  fx = x_i[22:0];
        sy = y_i[31];  ey = y_i[30:23];  fy = y_i[22:0];

        xnan = (ex == '1) && (fx != '0);
        ynan = (ey == '1) && (fy != '0);
        xinf = (ex == '1) && (fx == '0);
        yinf = (ey == '1) && (fy == '0);
        xzr  = (ex == '0);
        yzr  = (ey == '0);

        // order by magnitude
        swap = {ey, fy} > {ex, fx};
        bs = swap ? sy : sx;   be = swap ? ey : ex;   bf = swap ? fy : fx;
        ss = swap ? sx : sy;   se = swap ? ex : ey;   sf = swap ? fx : fy;

        mb   = {1'b1, bf, 3'b000};
        ms   = {1'b1, sf, 3'b000};
        dexp = be - se;
        if (dexp >= 8'(EXT_W)) begin
            msh = '0;
            stk = 1'b1;
        end else begin
            msh = ms >> dexp;
            stk = |(ms & (({{(EXT_W-1){1'b0}}, 1'b1} << dexp) - {{(EXT_W-1){1'b0}}, 1'b1}));
        end
        msh[0] = msh[0] | stk;

        sub = bs ^ ss;
        if (sub) sum_w = {1'b0, mb} - {1'b0, msh};
        else     sum_w = {1'b0, mb} + {1'b0, msh};

        lz = lzc_ext(sum_w[EXT_W-1:0]);
        ew = $signed({2'b00, be});
        if (sum_w[EXT_W]) begin
            norm = {sum_w[EXT_W:2], sum_w[1] | sum_w[0]};
            ew   = ew + 10'sd1;
        end else begin
            norm = sum_w[EXT_W-1:0] << lz;
            ew   = ew - $signed({5'b00000, lz});
        end
        tiny = (ew <= 10'sd0);

        // round to nearest, ties to even
        mant = norm[EXT_W-1:3];
        g    = norm[2];
        rs   = norm[1] | norm[0];
        up   = g & (rs | mant[0]);
        mrnd = {1'b0, mant} + {{(FRAC_W+1){1'b0}}, up};
        if (mrnd[FRAC_W+1]) begin
            frac = mrnd[FRAC_W:1];
            ew   = ew + 10'sd1;
        end else begin
            frac = mrnd[FRAC_W-1:0];
        end

        if (sub && (sum_w == '0))
            gen = '0;                                   // exact cancellation: +0
        else if (tiny)
            gen = {bs, 31'h0};
        else if (ew >= 10'sd255)
            gen = {bs, 8'hFF, 23'h0};
        else
            gen = {bs, ew[7:0], frac};

        if (xnan || ynan)
            z_o = FP32_QNAN;
        else if (xinf && yinf)
            z_o = (sx != sy) ? FP32_QNAN : {sx, 8'hFF, 23'h0};
        else if (xinf)
            z_o = {sx, 8'hFF, 23'h0};
        else if (yinf)
            z_o = {sy, 8'hFF, 23'h0};
        else if (xzr && yzr)
            z_o = {sx & sy, 31'h0};
        else if (xzr)
            z_o = y_i;
        else if (yzr)
            z_o = x_i;
        else
            z_o = gen;
    end

endmodule

// File: rtl/bfdot_acc_unit.sv
module bfdot_acc_unit
    import bfdot_pkg::*;
#(
    parameter int unsigned MAX_LANES = 4,
    localparam int unsigned HALF_LANES = MAX_LANES / 2,
    localparam int unsigned VEC_W      = MAX_LANES * FP_W,
    localparam int unsigned LANE_IDX_W = $clog2(MAX_LANES),
    localparam int unsigned IDX_W      = (HALF_LANES > 1) ? $clog2(HALF_LANES) : 1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             wide_mode,
    input  logic             bcast_mode,
    input  logic [IDX_W-1:0] bcast_sel,
    input  logic [VEC_W-1:0] vec_a,
    input  logic [VEC_W-1:0] vec_b,
    input  logic [VEC_W-1:0] acc_in,
    output logic             busy,
    output logic             done,
    output logic [VEC_W-1:0] acc_out
);

    localparam int unsigned ELEMS = FP_W / BF_W;

    seq_state_t state_q, state_d;

    logic [LANE_IDX_W-1:0]           lane_q, last_lane;
    logic                            wide_q, bcast_q;
    logic [IDX_W-1:0]                sel_q;
    logic [MAX_LANES-1:0][FP_W-1:0]  a_q, b_q, acc_q;
    logic [ELEMS-1:0][FP_W-1:0]      prod_d, prod_q;
    logic [FP_W-1:0]                 sum_q;
    logic [FP_W-1:0]                 cur_a, cur_b;
    logic [FP_W-1:0]                 add_x, add_y, add_z;

    // ---------------- operand selection ----------------
    assign last_lane = wide_q ? LANE_IDX_W'(MAX_LANES - 1) : LANE_IDX_W'(HALF_LANES - 1);
    assign cur_a     = a_q[lane_q];
    assign cur_b     = bcast_q ? b_q[LANE_IDX_W'(sel_q)] : b_q[lane_q];

    // ---------------- products: one multiplier per element ----------------
    for (genvar k = 0; k < ELEMS; k++) begin : g_mul
        bf16_mul u_mul (
            .a_i (cur_a[k*BF_W +: BF_W]),
            .b_i (cur_b[k*BF_W +: BF_W]),
            .p_o (prod_d[k])
        );
    end

    // ---------------- shared adder ----------------
    assign add_x = (state_q == ST_ACCUM) ? acc_q[lane_q] : prod_q[0];
    assign add_y = (state_q == ST_ACCUM) ? sum_q         : prod_q[1];

    fp32_add u_add (
        .x_i (add_x),
        .y_i (add_y),
        .z_o (add_z)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_MUL;                 // accept
            ST_MUL:   state_d = ST_PSUM;                           // mul_to_sum
            ST_PSUM:  state_d = ST_ACCUM;                          // sum_to_acc
            ST_ACCUM: state_d = (lane_q == last_lane) ? ST_FIN     // last_lane
                                                      : ST_MUL;    // next_lane
            ST_FIN:   state_d = ST_IDLE;                           // retire
            default:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q  <= '0;
            wide_q  <= 1'b0;
            bcast_q <= 1'b0;
            sel_q   <= '0;
            a_q     <= '0;
            b_q     <= '0;
            acc_q   <= '0;
            prod_q  <= '0;
            sum_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        lane_q  <= '0;
                        wide_q  <= wide_mode;
                        bcast_q <= bcast_mode;
                        sel_q   <= bcast_sel;
                        a_q     <= vec_a;
                        b_q     <= vec_b;
                        acc_q   <= acc_in;
                    end
                end
                ST_MUL:   prod_q <= prod_d;
                ST_PSUM:  sum_q  <= add_z;
                ST_ACCUM: begin
                    acc_q[lane_q] <= add_z;
                    if (lane_q != last_lane) lane_q <= lane_q + 1'b1;
                end
                ST_FIN:   ;
                default:  ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_FIN);
        acc_out = acc_q;
    end

    // ---------------- assertions ----------------
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);                                         // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                    // R8
    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);                                                    // R8
    AST_LANE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lane_q <= last_lane));                                    // R2
    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !wide_q) |-> $stable(acc_q[MAX_LANES-1:HALF_LANES])); // R2
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(wide_q) && $stable(bcast_q) && $stable(sel_q))); // R9
    AST_NAN_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ((add_z[30:23] == 8'hFF) && (add_z[22:0] != '0)) |-> (add_z == FP32_QNAN)); // R5
    AST_NO_SUBNORM: assert property (@(posedge clk) disable iff (!rst_n)
        ((add_z[30:23] == 8'h00) || (prod_d[0][30:23] == 8'h00)) |->
        ((add_z[30:23] != 8'h00 || add_z[22:0] == '0) &&
         (prod_d[0][30:23] != 8'h00 || prod_d[0][22:0] == '0)));           // R7

endmodule

// File: tb/tb_bfdot_acc_unit.sv
module tb_bfdot_acc_unit;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         wide_mode = 1'b0;
    logic         bcast_mode = 1'b0;
    logic [0:0]   bcast_sel = 1'b0;
    logic [127:0] vec_a = '0, vec_b = '0, acc_in = '0;
    logic         busy, done;
    logic [127:0] acc_out;

    int n_chk = 0;
    int n_fail = 0;

    bfdot_acc_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode),
        .bcast_mode(bcast_mode), .bcast_sel(bcast_sel), .vec_a(vec_a),
        .vec_b(vec_b), .acc_in(acc_in), .busy(busy), .done(done), .acc_out(acc_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // Issue one operation; returns result at done and cycles from accept edge.
    task automatic run_op(input bit wide, input bit bcast, input bit sel,
                          input logic [127:0] a, input logic [127:0] b,
                          input logic [127:0] acc, input bit disturb,
                          output logic [127:0] res, output int cyc, output bit busy_drop);
        @(negedge clk);
        wide_mode = wide; bcast_mode = bcast; bcast_sel = sel;
        vec_a = a; vec_b = b; acc_in = acc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        busy_drop = 1'b0;
        while (!done && cyc < 64) begin
            if (!busy) busy_drop = 1'b1;
            if (disturb && cyc == 2) begin
                start = 1'b1; vec_a = ~a; vec_b = ~b; acc_in = ~acc;
                wide_mode = !wide; bcast_mode = !bcast; bcast_sel = !sel;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        res = acc_out;
    endtask

    task automatic t_reset();
        chk("R10", "busy after reset", {127'b0, busy}, 128'd0);
        chk("R10", "done after reset", {127'b0, done}, 128'd0);
        chk("R10", "acc_out after reset", acc_out, 128'd0);
    endtask

    localparam logic [127:0] BA   = {32'h3FC0_3FC0, 32'h3F80_BF80, 32'h4000_4000, 32'h4000_3F80};
    localparam logic [127:0] BB   = {32'h4000_4000, 32'h3F80_3F80, 32'h3F00_4000, 32'h4080_4040};
    localparam logic [127:0] BACC = {32'hBF80_0000, 32'h8000_0000, 32'h0000_0000, 32'h3F80_0000};

    task automatic t_basic_wide();
        logic [127:0] r; int c; bit bd;
        run_op(1'b1, 1'b0, 1'b0, BA, BB, BACC, 1'b0, r, c, bd);
        chk("R1", "four-lane dot accumulate", r,
            {32'h40A0_0000, 32'h0000_0000, 32'h40A0_0000, 32'h4140_0000});
        chk("R8", "four-lane done latency", 128'(c), 128'd13);
        chk("R8", "busy held until done", {127'b0, bd}, 128'd0);
        @(negedge clk);
        chk("R8", "done is one pulse", {127'b0, done}, 128'd0);
        chk("R8", "idle after done", {127'b0, busy}, 128'd0);
    endtask

    task automatic t_basic_narrow();
        logic [127:0] r; int c; bit bd;
        run_op(1'b0, 1'b0, 1'b0, BA, BB, BACC, 1'b0, r, c, bd);
        chk("R2", "two-lane form, upper lanes pass", r,
            {32'hBF80_0000, 32'h8000_0000, 32'h40A0_0000, 32'h4140_0000});
        chk("R8", "two-lane done latency", 128'(c), 128'd7);
    endtask

    task automatic t_broadcast();
        logic [127:0] r; int c; bit bd;
        logic [127:0] a, b;
        a = {32'h0000_4040, 32'h4080_3F00, 32'h4000_4080, 32'h4000_3F80};
        b = {32'h7FC0_7FC0, 32'h7FC0_7FC0, 32'h3F00_4000, 32'h3F80_3F80};
        run_op(1'b1, 1'b1, 1'b1, a, b,
               {32'h4000_0000, 32'h3F80_0000, 32'h0, 32'h0}, 1'b0, r, c, bd);
        chk("R3", "broadcast pair 1", r,
            {32'h4100_0000, 32'h4080_0000, 32'h4110_0000, 32'h4040_0000});
        run_op(1'b1, 1'b1, 1'b0, a, b, 128'd0, 1'b0, r, c, bd);
        chk("R3", "broadcast pair 0", r,
            {32'h4040_0000, 32'h4090_0000, 32'h40C0_0000, 32'h4040_0000});
    endtask

    task automatic t_nan();
        logic [127:0] r; int c; bit bd;
        run_op(1'b1, 1'b0, 1'b0,
               {32'h3F80_7F81, 32'h0000_7F80, 32'h3F80_7F80, 32'h3F80_7F80},
               {32'h3F80_3F80, 32'h0000_4000, 32'h0000_3F80, 32'h3F80_0000},
               {32'h3F80_0000, 32'h3F80_0000, 32'hFF80_0000, 32'h0000_0000},
               1'b0, r, c, bd);
        chk("R5", "inf*0 gives default NaN", 128'(r[31:0]), 128'h7FC0_0000);
        chk("R5", "inf minus inf gives default NaN", 128'(r[63:32]), 128'h7FC0_0000);
        chk("R6", "inf plus finite", 128'(r[95:64]), 128'h7F80_0000);
        chk("R5", "NaN input gives default NaN", 128'(r[127:96]), 128'h7FC0_0000);
    endtask

    task automatic t_overflow();
        logic [127:0] r; int c; bit bd;
        run_op(1'b1, 1'b0, 1'b0,
               {32'h0000_3F80, 32'h7F00_7F00, 32'h0000_FF00, 32'h0000_7F00},
               {32'h0000_3F80, 32'h3F80_3F80, 32'h0000_4000, 32'h0000_4000},
               {32'h7F7F_FFFF, 32'h0, 32'h0, 32'h0}, 1'b0, r, c, bd);
        chk("R6", "product overflow, overflowing sum, max kept", r,
            {32'h7F7F_FFFF, 32'h7F80_0000, 32'hFF80_0000, 32'h7F80_0000});
    endtask

    task automatic t_flush();
        logic [127:0] r; int c; bit bd;
        run_op(1'b1, 1'b0, 1'b0,
               {32'h0000_8080, 32'h8000_8000, 32'h0000_0080, 32'h0000_0001},
               {32'h0000_3F80, 32'h3F80_3F80, 32'h0000_3F00, 32'h0000_3F80},
               {32'h00C0_0000, 32'h8040_0000, 32'h0000_0000, 32'h3F80_0000},
               1'b0, r, c, bd);
        chk("R7", "subnormal input flushed", 128'(r[31:0]), 128'h3F80_0000);
        chk("R7", "tiny product flushed", 128'(r[63:32]), 128'h0);
        chk("R7", "negative zeros keep sign", 128'(r[95:64]), 128'h8000_0000);
        chk("R7", "subnormal sum flushed", 128'(r[127:96]), 128'h0);
    endtask

    task automatic t_rounding();
        logic [127:0] r; int c; bit bd;
        run_op(1'b1, 1'b0, 1'b0,
               {32'h3B80_BF80, 32'h3980_3980, 32'h0000_3980, 32'h0000_3980},
               {32'h3F80_3F80, 32'h3900_3980, 32'h0000_3980, 32'h0000_3980},
               {32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0001, 32'h3F80_0000},
               1'b0, r, c, bd);
        chk("R4", "tie to even stays", 128'(r[31:0]), 128'h3F80_0000);
        chk("R4", "tie to even rounds up", 128'(r[63:32]), 128'h3F80_0002);
        chk("R4", "above half rounds up", 128'(r[95:64]), 128'h3F80_0001);
        chk("R4", "cancellation renormalised", 128'(r[127:96]), 128'h3B80_0000);
    endtask

    task automatic t_ignore_start();
        logic [127:0] r; int c; bit bd;
        run_op(1'b1, 1'b0, 1'b0, BA, BB, BACC, 1'b1, r, c, bd);
        chk("R9", "start while busy and input changes ignored", r,
            {32'h40A0_0000, 32'h0000_0000, 32'h40A0_0000, 32'h4140_0000});
        chk("R9", "latency unchanged by second start", 128'(c), 128'd13);
        @(negedge clk);
        chk("R9", "no extra operation started", {127'b0, busy}, 128'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_wide();
        t_basic_narrow();
        t_broadcast();
        t_nan();
        t_overflow();
        t_flush();
        t_rounding();
        t_ignore_start();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule